// File: doc/BRIEF.md
# Carry-Less Multiplier Unit

This unit multiplies two 32-bit operands without carries. Every place where an ordinary multiplier would add partial products, this one takes the bitwise XOR. The result is a 63-bit polynomial product over GF(2). That product is held in a 64-bit internal word whose top bit is always zero.

The unit builds one partial product per bit of operand B. Each partial product is a shifted copy of operand A, or zero when that bit of B is clear. These partial products are folded by a balanced XOR tree that is five levels deep for 32-bit operands.

A two-bit operation select picks the 32-bit window of the product that is returned:

| Select | Window | Product bits |
|--------|--------|--------------|
| 00 | low | 31..0 |
| 01 | high | 63..32 |
| 10 | reversed | 62..31 |
| 11 | none | returns zero |

A parameter places an optional register after the window selection. When the register is present, a valid strobe travels alongside the result.

Top module: `clmul_unit`

## Requirements
- R1: With select 00 the result is bits 31..0 of the carry-less product of A and B (for example A=0xD, B=0xB gives 0x7F).
- R2: With select 01 the result is bits 63..32 of the carry-less product.
- R3: When B is zero the result is zero for every select.
- R4: When B equals 1 the low window returns A and the high window returns zero.
- R5: In the high window, result bit 31 (product bit 63) is always zero.
- R6: With select 10 the result is bits 62..31 of the carry-less product.
- R7: Select 11 returns zero whatever the operands are.
- R8: With the output register enabled, result_o and valid_o reflect the inputs of the cycle before, and valid_o equals valid_i delayed by one clock.
- R9: With the output register enabled, result_o keeps its value through any cycle in which valid_i is low.
- R10: While rst_ni is low, valid_o and result_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and select are presented this cycle |
| op_i | input | 2 | Window select: 00 low, 01 high, 10 reversed, 11 zero |
| a_i | input | 32 | Operand A (the shifted operand) |
| b_i | input | 32 | Operand B (selects the partial products) |
| valid_o | output | 1 | Result is valid |
| result_o | output | 32 | Selected product window |

## Verification
The assertions check the following on every cycle:
- the selected window is zero for a zero B operand and for select 11;
- the top bit of the high window stays clear;
- a B of one passes A through in the low window;
- valid_o trails valid_i by exactly one clock;
- the registered result stays put while valid_i is low.

Only the bench scenarios can show that the full XOR tree produces the right product bits in each window, because that needs a reference product. The bench supplies one for a table of operand patterns and for hand-derived corner values: the all-ones square and the single top-bit square. The same holds for the reset behaviour, including a reset asserted in the middle of a run.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

   typedef enum logic [1:0] {
      OP_LOW  = 2'b00,
      OP_HIGH = 2'b01,
      OP_REV  = 2'b10,
      OP_NONE = 2'b11
   } clmul_op_e;

endpackage

// File: rtl/clmul_pp_gen.sv
module clmul_pp_gen #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned PW    = 2 * DATA_W
) (
   input  logic [DATA_W-1:0]          a_i,
   input  logic [DATA_W-1:0]          b_i,
   output logic [DATA_W-1:0][PW-1:0]  pp_o
);

   logic [PW-1:0] a_wide;
   assign a_wide = {{DATA_W{1'b0}}, a_i};

   // One row per bit of B: A shifted by the row index, or nothing.
   for (genvar row = 0; row < DATA_W; row++) begin : g_row
      assign pp_o[row] = b_i[row] ? (a_wide << row) : '0;
   end

endmodule

// File: rtl/clmul_xor_tree.sv
module clmul_xor_tree #(
   parameter int unsigned LEAVES = 32,
   parameter int unsigned PW     = 64,
   localparam int unsigned DEPTH = $clog2(LEAVES)
) (
   input  logic [LEAVES-1:0][PW-1:0] leaf_i,
   output logic [PW-1:0]             sum_o
);

   if (LEAVES < 2 || (LEAVES & (LEAVES - 1)) != 0) begin : g_bad_leaves
      $error("clmul_xor_tree: LEAVES must be a power of two of at least 2");
   end

   // Each level halves the number of terms; adjacent pairs are XORed.
   for (genvar lvl = 1; lvl <= DEPTH; lvl++) begin : g_lvl
      localparam int unsigned CNT = LEAVES >> lvl;
      logic [CNT-1:0][PW-1:0] v;
      for (genvar k = 0; k < CNT; k++) begin : g_node
         if (lvl == 1) begin : g_first
            assign v[k] = leaf_i[2*k] ^ leaf_i[2*k+1];
         end else begin : g_inner
            assign v[k] = g_lvl[lvl-1].v[2*k] ^ g_lvl[lvl-1].v[2*k+1];
         end
      end
   end

   assign sum_o = g_lvl[DEPTH].v[0];

endmodule

// File: rtl/clmul_view_sel.sv
module clmul_view_sel
   import clmul_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned PW    = 2 * DATA_W
) (
   input  logic [PW-1:0]     prod_i,
   input  logic [1:0]        op_i,
   output logic [DATA_W-1:0] view_o
);

   always_comb begin
      unique case (clmul_op_e'(op_i))
         OP_LOW:  view_o = prod_i[DATA_W-1:0];
         OP_HIGH: view_o = prod_i[PW-1:DATA_W];
         OP_REV:  view_o = prod_i[PW-2:DATA_W-1];
         default: view_o = '0;
      endcase
   end

endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
   import clmul_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          OUT_REG   = 1'b1,
   localparam int unsigned PW       = 2 * DATA_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] result_o
);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("clmul_unit: DATA_W must be a power of two of at least 2");
   end

   logic [DATA_W-1:0][PW-1:0] pp;
   logic [PW-1:0]             prod;
   logic [DATA_W-1:0]         view;

   clmul_pp_gen #(
      .DATA_W (DATA_W)
   ) i_pp_gen (
      .a_i  (a_i),
      .b_i  (b_i),
      .pp_o (pp)
   );

   clmul_xor_tree #(
      .LEAVES (DATA_W),
      .PW     (PW)
   ) i_xor_tree (
      .leaf_i (pp),
      .sum_o  (prod)
   );

   clmul_view_sel #(
      .DATA_W (DATA_W)
   ) i_view_sel (
      .prod_i (prod),
      .op_i   (op_i),
      .view_o (view)
   );

   if (OUT_REG) begin : g_reg
      logic              valid_q;
      logic [DATA_W-1:0] result_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            valid_q  <= 1'b0;
            result_q <= '0;
         end else begin
            valid_q <= valid_i;
            if (valid_i) begin
               result_q <= view;
            end
         end
      end

      assign valid_o  = valid_q;
      assign result_o = result_q;

      // R8: the strobe trails the input strobe by one clock
      a_r8_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
         1'b1 |=> valid_o == $past(valid_i));

      // R8: a presented result appears at the output on the next clock
      a_r8_result_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_i |=> result_o == $past(view));

      // R9: the result is held while no new operands arrive
      a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !valid_i |=> $stable(result_o));
   end else begin : g_comb
      assign valid_o  = valid_i;
      assign result_o = view;
   end

   // R3: a zero B operand gives a zero window for every select
   a_r3_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && b_i == '0) |-> view == '0);

   // R4: multiplying by one passes A through in the low window
   a_r4_unit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && b_i == DATA_W'(1) && op_i == OP_LOW) |-> view == a_i);

   // R5: the top bit of the high window is never set
   a_r5_high_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_HIGH) |-> !view[DATA_W-1]);

   // R7: the unused select returns zero
   a_r7_none_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_NONE) |-> view == '0);

endmodule

// File: tb/test_clmul_unit.sv
module test_clmul_unit;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        valid_i = 1'b0;
   logic [1:0]  op_i = 2'b00;
   logic [31:0] a_i = '0;
   logic [31:0] b_i = '0;
   logic        valid_o;
   logic [31:0] result_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk_i = ~clk_i;

   clmul_unit #(.DATA_W(32), .OUT_REG(1'b1)) i_clmul_unit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_i),
      .op_i     (op_i),
      .a_i      (a_i),
      .b_i      (b_i),
      .valid_o  (valid_o),
      .result_o (result_o)
   );

   localparam int NV = 8;
   localparam logic [31:0] VA [NV] = '{32'h12345678, 32'h12345678, 32'h12345678,
      32'hDEADBEEF, 32'hDEADBEEF, 32'hA5A5A5A5, 32'h00000003, 32'hCAFEF00D};
   localparam logic [31:0] VB [NV] = '{32'h9ABCDEF0, 32'h9ABCDEF0, 32'h9ABCDEF0,
      32'h0000FFFF, 32'hFFFF0000, 32'h5A5A5A5A, 32'h00000003, 32'h87654321};
   localparam logic [1:0]  VO [NV] = '{2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b10,
      2'b00, 2'b11};

   // Reference from the definition: shift-and-XOR accumulation.
   function automatic logic [31:0] ref_view(logic [31:0] a, logic [31:0] b, logic [1:0] op);
      logic [63:0] p = '0;
      for (int i = 0; i < 32; i++) begin
         if (b[i]) p = p ^ ({32'b0, a} << i);
      end
      case (op)
         2'b00:   return p[31:0];
         2'b01:   return p[63:32];
         2'b10:   return p[62:31];
         default: return 32'h0;
      endcase
   endfunction

   function automatic string op_tag(logic [1:0] op);
      case (op)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op);
      @(negedge clk_i);
      a_i = a; b_i = b; op_i = op; valid_i = 1'b1;
      @(negedge clk_i);
      valid_i = 1'b0;
   endtask

   initial begin
      // R10: reset state
      repeat (2) @(negedge clk_i);
      check("R10 valid_o in reset", {31'b0, valid_o}, 32'h0);
      check("R10 result_o in reset", result_o, 32'h0);
      rst_ni = 1'b1;

      // Table walk
      for (int i = 0; i < NV; i++) begin
         apply(VA[i], VB[i], VO[i]);
         check(op_tag(VO[i]), result_o, ref_view(VA[i], VB[i], VO[i]));
         check("R8 valid_o after valid_i", {31'b0, valid_o}, 32'h1);
      end

      // R8 and R9: strobe drops, result holds while operands change
      a_i = 32'hFFFFFFFF; b_i = 32'h13579BDF; op_i = 2'b01;
      @(negedge clk_i);
      check("R8 valid_o low", {31'b0, valid_o}, 32'h0);
      check("R9 held result", result_o, ref_view(VA[NV-1], VB[NV-1], VO[NV-1]));
      @(negedge clk_i);
      check("R9 held result second cycle", result_o, 32'h0);

      // Directed corner cases
      apply(32'h0000000D, 32'h0000000B, 2'b00);
      check("R1 small example", result_o, 32'h0000007F);
      apply(32'hFFFFFFFF, 32'h00000000, 2'b10);
      check("R3 zero B reversed", result_o, 32'h0);
      apply(32'hFFFFFFFF, 32'h00000000, 2'b01);
      check("R3 zero B high", result_o, 32'h0);
      apply(32'h89ABCDEF, 32'h00000001, 2'b00);
      check("R4 unit B low", result_o, 32'h89ABCDEF);
      apply(32'h89ABCDEF, 32'h00000001, 2'b01);
      check("R4 unit B high", result_o, 32'h0);
      apply(32'h80000000, 32'h80000000, 2'b01);
      check("R2 top-bit square high", result_o, 32'h40000000);
      apply(32'h80000000, 32'h80000000, 2'b10);
      check("R6 top-bit square reversed", result_o, 32'h80000000);
      apply(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b00);
      check("R1 all-ones low", result_o, 32'h55555555);
      apply(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b01);
      check("R5 all-ones high", result_o, 32'h55555555);
      apply(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b10);
      check("R6 all-ones reversed", result_o, 32'hAAAAAAAA);
      apply(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b11);
      check("R7 select 11", result_o, 32'h0);

      // R10: reset in the middle of a run
      apply(32'h12345678, 32'h0000FFFF, 2'b00);
      @(negedge clk_i);
      rst_ni = 1'b0;
      #1;
      check("R10 result_o mid-run reset", result_o, 32'h0);
      check("R10 valid_o mid-run reset", {31'b0, valid_o}, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule